// File: doc/BRIEF.md
# Up/Down Wiper Tap Controller

This block is the digital control core of a 128-position digital potentiometer. A host drives three active-low-style control lines asynchronously to the system clock: a select line, an increment strobe and a direction line. While the block is selected, each falling edge of the increment strobe moves a 7-bit tap register one position up or down. The tap register selects the wiper position, and it stops at either end of the range instead of wrapping.

One non-volatile storage word keeps a wiper position across resets. When the host releases the select line while the increment strobe is high, the current tap value is written into that word. A programmable busy interval models the write time. During that interval the block refuses further moves and further store requests. After every ordinary reset, the block waits a programmable power-up delay and then loads the stored word into the tap register. A separate factory-reset input sets the stored word to mid-scale.

Top module: `updown_tap_ctrl`

## Requirements
- R1: While reset is applied and until the power-up delay of PWRUP_CYCLES clocks after reset release has run out, the tap output is 0 and the busy output is 0. When the delay ends, the tap output takes the stored value.
- R2: A factory-reset pulse sets the stored value to 64 (mid-scale). An ordinary reset does not alter the stored value.
- R3: While select is low (0), each falling edge of the increment strobe with the direction line high (1) raises the tap by exactly one.
- R4: While select is low, each falling edge of the increment strobe with the direction line low (0) lowers the tap by exactly one.
- R5: An up step at tap 127 leaves the tap at 127.
- R6: A down step at tap 0 leaves the tap at 0.
- R7: While select is high (1), falling edges of the increment strobe do not change the tap.
- R8: A rising edge of select while the increment strobe is high writes the tap into the stored value and holds busy high for exactly STORE_CYCLES clocks. The next ordinary reset recalls that value.
- R9: A rising edge of select while the increment strobe is low writes nothing and leaves busy low.
- R10: While busy is high, increment falling edges do not move the tap and a new store request is dropped, so it does not extend the busy interval.
- R11: The direction line may change during one selection. Each step follows the level of the direction line at its own increment edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; starts the recall sequence |
| factory_rst | input | 1 | Synchronous active-high; sets the stored value to mid-scale |
| sel_n_i | input | 1 | Asynchronous select, low = selected |
| inc_n_i | input | 1 | Asynchronous increment strobe, acts on its falling edge |
| up_ndown_i | input | 1 | Asynchronous direction, high = up, low = down |
| tap_o | output | 7 | Current wiper tap position |
| store_busy_o | output | 1 | High while a store write is in progress |

## Verification
The assertions assume that the host keeps each control level steady for several clocks, so that the synchronized select and increment never change in the same sample. They also assume that factory reset is not pulsed in the middle of a store. Under those conditions the tap moves by at most one per clock, and a busy interval always runs its full length. The bench changes one input at a time on the falling clock edge and then waits six clocks before the next change or check, which is more than the three-register path from pin to tap. It applies factory reset only while no store is in progress.

// File: rtl/tapctl_pkg.sv
package tapctl_pkg;
    localparam int TAP_W    = 7;
    localparam int TAP_MAX  = (1 << TAP_W) - 1;
    localparam int TAP_MID  = 1 << (TAP_W - 1);

    typedef logic [TAP_W-1:0] tap_t;

    // synchronized control levels
    typedef struct packed {
        logic sel_n;
        logic inc_n;
        logic up;
    } ctl_t;

    localparam ctl_t CTL_IDLE = '{sel_n: 1'b1, inc_n: 1'b1, up: 1'b0};

    // single-cycle events derived from the control levels
    typedef struct packed {
        logic step_up;
        logic step_dn;
        logic store;
    } evt_t;

    function automatic tap_t sat_step(input tap_t v, input logic up);
        if (up)
            return (v == tap_t'(TAP_MAX)) ? v : v + tap_t'(1);
        else
            return (v == '0) ? v : v - tap_t'(1);
    endfunction
endpackage

// File: rtl/tapctl_sync.sv
module tapctl_sync
    import tapctl_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  ctl_t raw_i,
    output ctl_t sync_o
);
    ctl_t stage_q [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)
                    stage_q[g] <= CTL_IDLE;
                else if (g == 0)
                    stage_q[g] <= raw_i;
                else
                    stage_q[g] <= stage_q[(g == 0) ? 0 : g - 1];
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/tapctl_events.sv
module tapctl_events
    import tapctl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  ctl_t ctl_i,
    input  logic active_i,
    output evt_t evt_o
);
    ctl_t prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= CTL_IDLE;
        else     prev_q <= ctl_i;
    end

    logic inc_fall;
    logic sel_rise;

    always_comb begin
        inc_fall      = prev_q.inc_n && !ctl_i.inc_n;
        sel_rise      = !prev_q.sel_n && ctl_i.sel_n;
        evt_o.step_up = active_i && !ctl_i.sel_n && inc_fall && ctl_i.up;
        evt_o.step_dn = active_i && !ctl_i.sel_n && inc_fall && !ctl_i.up;
        evt_o.store   = active_i && sel_rise && ctl_i.inc_n;
    end
endmodule

// File: rtl/tapctl_nvcell.sv
module tapctl_nvcell
    import tapctl_pkg::*;
#(
    parameter int STORE_CYCLES = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic factory_rst,
    input  logic wr_en_i,
    input  tap_t wr_data_i,
    output tap_t rd_data_o,
    output logic busy_o
);
    localparam int CNT_W = $clog2(STORE_CYCLES + 1);

    tap_t             cell_q;
    logic [CNT_W-1:0] cnt_q;

    // storage word survives ordinary reset
    always_ff @(posedge clk) begin
        if (factory_rst)  cell_q <= tap_t'(TAP_MID);
        else if (wr_en_i) cell_q <= wr_data_i;
    end

    always_ff @(posedge clk) begin
        if (rst || factory_rst) cnt_q <= '0;
        else if (wr_en_i)       cnt_q <= CNT_W'(STORE_CYCLES);
        else if (cnt_q != '0)   cnt_q <= cnt_q - CNT_W'(1);
    end

    assign rd_data_o = cell_q;
    assign busy_o    = (cnt_q != '0);
endmodule

// File: rtl/updown_tap_ctrl.sv
module updown_tap_ctrl
    import tapctl_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int PWRUP_CYCLES = 32,
    parameter int STORE_CYCLES = 200
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             factory_rst,
    input  logic             sel_n_i,
    input  logic             inc_n_i,
    input  logic             up_ndown_i,
    output logic [TAP_W-1:0] tap_o,
    output logic             store_busy_o
);
    localparam int PW_W = $clog2(PWRUP_CYCLES + 1);

    ctl_t ctl_raw;
    ctl_t ctl_s;
    evt_t evt;
    tap_t nv_data;
    logic busy;
    logic recalled_q;
    logic [PW_W-1:0] pw_cnt_q;
    tap_t tap_q;

    assign ctl_raw = '{sel_n: sel_n_i, inc_n: inc_n_i, up: up_ndown_i};

    tapctl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw_i  (ctl_raw),
        .sync_o (ctl_s)
    );

    tapctl_events u_events (
        .clk      (clk),
        .rst      (rst),
        .ctl_i    (ctl_s),
        .active_i (recalled_q && !busy),
        .evt_o    (evt)
    );

    tapctl_nvcell #(.STORE_CYCLES(STORE_CYCLES)) u_nv (
        .clk         (clk),
        .rst         (rst),
        .factory_rst (factory_rst),
        .wr_en_i     (evt.store),
        .wr_data_i   (tap_q),
        .rd_data_o   (nv_data),
        .busy_o      (busy)
    );

    // power-up delay, recall, then saturating steps
    always_ff @(posedge clk) begin
        if (rst) begin
            pw_cnt_q   <= '0;
            recalled_q <= 1'b0;
            tap_q      <= '0;
        end else if (!recalled_q) begin
            if (pw_cnt_q == PW_W'(PWRUP_CYCLES - 1)) begin
                recalled_q <= 1'b1;
                tap_q      <= nv_data;
            end else begin
                pw_cnt_q <= pw_cnt_q + PW_W'(1);
            end
        end else if (evt.step_up || evt.step_dn) begin
            tap_q <= sat_step(tap_q, evt.step_up);
        end
    end

    assign tap_o        = tap_q;
    assign store_busy_o = busy;
endmodule

// File: rtl/tapctl_checker.sv
module tapctl_checker
    import tapctl_pkg::*;
#(
    parameter int STORE_CYCLES = 200
) (
    input logic clk,
    input logic rst,
    input logic factory_rst,
    input tap_t tap,
    input logic busy,
    input logic recalled
);
    localparam int RUN_W = $clog2(STORE_CYCLES + 2);
    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst || !busy)             run_q <= '0;
        else if (run_q != {RUN_W{1'b1}}) run_q <= run_q + RUN_W'(1);
    end

    // R1: tap sits at zero until recall
    assert_hold_zero_R1: assert property (@(posedge clk) disable iff (rst)
        !recalled |-> tap == '0);

    // R3 / R4: at most one position per clock once running
    assert_single_step_R3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(recalled)) |->
            (tap == $past(tap) || tap == $past(tap) + tap_t'(1) || tap == $past(tap) - tap_t'(1)));

    // R5: no wrap from top
    assert_no_wrap_top_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(recalled) && $past(tap) == tap_t'(TAP_MAX)) |-> tap != '0);

    // R6: no wrap from bottom
    assert_no_wrap_bottom_R6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(recalled) && $past(tap) == '0) |-> tap != tap_t'(TAP_MAX));

    // R10: busy freezes the tap
    assert_busy_freeze_R10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(busy) && $past(recalled)) |-> $stable(tap));

    // R8: busy lasts exactly STORE_CYCLES clocks
    assert_busy_length_R8: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && !$past(rst) && !$past(factory_rst)) |-> run_q == RUN_W'(STORE_CYCLES));
endmodule

bind updown_tap_ctrl tapctl_checker #(.STORE_CYCLES(STORE_CYCLES)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .factory_rst (factory_rst),
    .tap         (tap_o),
    .busy        (store_busy_o),
    .recalled    (recalled_q)
);

// File: tb/test_updown_tap_ctrl.sv
module test_updown_tap_ctrl;
    localparam int PWRUP = 32;
    localparam int STORE = 200;
    localparam int SETTLE = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       factory_rst = 1'b1;
    logic       sel_n = 1'b1;
    logic       inc_n = 1'b1;
    logic       ud = 1'b0;
    logic [6:0] tap;
    logic       busy;

    int checks = 0;
    int failures = 0;
    int exp_tap = 0;
    int exp_nv = 64;

    always #4 clk = ~clk;

    updown_tap_ctrl #(.SYNC_STAGES(2), .PWRUP_CYCLES(PWRUP), .STORE_CYCLES(STORE)) i_updown_tap_ctrl (
        .clk          (clk),
        .rst          (rst),
        .factory_rst  (factory_rst),
        .sel_n_i      (sel_n),
        .inc_n_i      (inc_n),
        .up_ndown_i   (ud),
        .tap_o        (tap),
        .store_busy_o (busy)
    );

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse(input logic up, input bit stay_low, input bit moves);
        ud = up;
        wait_cyc(SETTLE);
        inc_n = 1'b0;
        wait_cyc(SETTLE);
        if (moves) begin
            if (up) exp_tap = (exp_tap == 127) ? 127 : exp_tap + 1;
            else    exp_tap = (exp_tap == 0) ? 0 : exp_tap - 1;
        end
        if (!stay_low) begin
            inc_n = 1'b1;
            wait_cyc(SETTLE);
        end
    endtask

    task automatic do_reset(input bit factory);
        @(negedge clk);
        rst = 1'b1;
        factory_rst = factory;
        sel_n = 1'b1;
        inc_n = 1'b1;
        wait_cyc(3);
        chk("R1 tap in reset", int'(tap), 0);
        chk("R1 busy in reset", int'(busy), 0);
        rst = 1'b0;
        factory_rst = 1'b0;
        if (factory) exp_nv = 64;
        wait_cyc(PWRUP - 8);
        chk("R1 tap before recall", int'(tap), 0);
        wait_cyc(12);
        exp_tap = exp_nv;
        chk("R1 tap after recall", int'(tap), exp_tap);
    endtask

    task automatic t_powerup_factory;
        do_reset(1'b1);
        chk("R2 factory value 64", int'(tap), 64);
    endtask

    task automatic t_steps_and_store;
        sel_n = 1'b0;
        wait_cyc(SETTLE);
        for (int i = 0; i < 3; i++) pulse(1'b1, 1'b0, 1'b1);
        chk("R3 up steps", int'(tap), 67);
        pulse(1'b0, 1'b0, 1'b1);
        chk("R4 down step", int'(tap), 66);
        pulse(1'b1, 1'b0, 1'b1);
        pulse(1'b0, 1'b0, 1'b1);
        pulse(1'b0, 1'b0, 1'b1);
        chk("R11 mixed directions", int'(tap), exp_tap);
        chk("R11 mixed value", int'(tap), 65);
        // store: release select with increment high
        sel_n = 1'b1;
        exp_nv = exp_tap;
        wait_cyc(SETTLE);
        chk("R8 busy after store", int'(busy), 1);
        // moves and second store during busy
        sel_n = 1'b0;
        wait_cyc(SETTLE);
        pulse(1'b1, 1'b0, 1'b0);
        chk("R10 no move while busy", int'(tap), exp_tap);
        sel_n = 1'b1;
        wait_cyc(SETTLE);
        wait_cyc(150);
        chk("R8 busy still high", int'(busy), 1);
        wait_cyc(20);
        chk("R10 dropped store keeps interval", int'(busy), 0);
        do_reset(1'b0);
        chk("R8 recall stored value", int'(tap), 65);
        chk("R2 ordinary reset keeps value", int'(tap), exp_nv);
    endtask

    task automatic t_standby_ignored;
        for (int i = 0; i < 3; i++) pulse(1'b1, 1'b0, 1'b0);
        chk("R7 standby ignores increments", int'(tap), exp_tap);
    endtask

    task automatic t_saturate_top;
        sel_n = 1'b0;
        wait_cyc(SETTLE);
        for (int i = 0; i < 64; i++) pulse(1'b1, 1'b0, 1'b1);
        chk("R5 reached top", int'(tap), 127);
        pulse(1'b1, 1'b0, 1'b1);
        chk("R5 up at top holds", int'(tap), 127);
    endtask

    task automatic t_no_store;
        pulse(1'b0, 1'b1, 1'b1);
        chk("R4 step leaving strobe low", int'(tap), 126);
        sel_n = 1'b1;
        wait_cyc(3);
        chk("R9 busy low at release", int'(busy), 0);
        wait_cyc(SETTLE);
        chk("R9 busy stays low", int'(busy), 0);
        inc_n = 1'b1;
        wait_cyc(SETTLE);
        chk("R9 tap kept", int'(tap), 126);
        do_reset(1'b0);
        chk("R9 old value recalled", int'(tap), 65);
    endtask

    task automatic t_saturate_bottom;
        sel_n = 1'b0;
        wait_cyc(SETTLE);
        for (int i = 0; i < 66; i++) pulse(1'b0, 1'b0, 1'b1);
        chk("R6 reached bottom", int'(tap), 0);
        pulse(1'b0, 1'b0, 1'b1);
        chk("R6 down at bottom holds", int'(tap), 0);
        sel_n = 1'b1;
        exp_nv = 0;
        wait_cyc(STORE + 12);
        chk("R8 busy ended", int'(busy), 0);
        do_reset(1'b0);
        chk("R8 recall zero", int'(tap), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_powerup_factory();
        t_steps_and_store();
        t_standby_ignored();
        t_saturate_top();
        t_no_store();
        t_saturate_bottom();
        t_powerup_factory();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule